// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns a stream of stereo PCM sample pairs into a one-bit serial audio stream and acts as the master of the serial bus. It derives the serial bit clock from the system clock, drives the word-select line, and shifts out each pair inside a frame of 32, 48 or 64 bit periods. Samples of 16 to 24 bits are supported. The serial data can be placed in five ways: left-justified, right-justified, I2S with a one-bit delay, DSP with the data starting on the sync pulse, and DSP with the data one bit after the pulse. Each word can be sent MSB first or LSB first.

Sample pairs arrive through a valid/ready handshake into a single holding stage. At every frame start the held pair becomes the frame's data, together with the configuration inputs as they stand on that cycle. Frames keep running whether or not a pair is waiting. When none is waiting, the frame carries zeros and a flag is pulsed.

Top module: `sat_tx`

## Requirements
- R1: A frame lasts 32, 48 or 64 bit periods for `cfg_ratio` 0, 1 or 2 (3 acts as 64). In the left-justified, right-justified and I2S placements `lrck_o` is low for the first half of the frame (left word) and high for the second half (right word).
- R2: Left-justified (`cfg_fmt`=0): bit k of a word (k=0 first) goes in slot k of its half-frame, and the slots after the word carry 0.
- R3: Right-justified (`cfg_fmt`=1): the word ends in the last slot of its half-frame and the slots before it carry 0. With 16 bits at ratio 32, the output therefore equals the left-justified output.
- R4: I2S (`cfg_fmt`=2): bit k goes in slot k+1 of its half-frame. When the word fills the half-frame, its last bit spills into slot 0 of the next half-frame. For the right word this is slot 0 of the next frame. In all other cases slot 0 carries 0.
- R5: DSP early (`cfg_fmt`=3): `lrck_o` is high for slot 0 of the frame only. The left word occupies slots 0..W-1 and the right word follows at once in slots W..2W-1.
- R6: DSP late (`cfg_fmt`=4): `lrck_o` is as in R5, the left word starts in slot 1 and the right word follows at once. When the two words fill the frame, the last right bit goes in slot 0 of the next frame. Otherwise slot 0 carries 0.
- R7: `cfg_lsb_first`=0 sends bit W-1 of the W-bit word first; `cfg_lsb_first`=1 sends bit 0 first. Sample bits at positions W and above are ignored.
- R8: `sclk_o` has a period of 2*HALF_DIV system clocks. `sdata_o` and `lrck_o` change only on the system clock edge on which `sclk_o` falls.
- R9: If no pair is held when a frame starts, the frame carries zero sample words and `underrun_o` is high for exactly the one system clock on which that frame's first slot begins. Otherwise `underrun_o` stays low.
- R10: Configuration inputs are taken only when a frame starts. A change in the middle of a frame leaves the rest of that frame unchanged.
- R11: `in_ready` is high while the holding stage is empty. It goes low on the cycle after a transfer and stays low until the next frame start. Pairs are sent in the order they were accepted.
- R12: During reset `sclk_o`, `lrck_o`, `sdata_o` and `underrun_o` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding stage free |
| in_left | input | 24 | Left sample, right-aligned |
| in_right | input | 24 | Right sample, right-aligned |
| cfg_fmt | input | 3 | Placement: 0 LJ, 1 RJ, 2 I2S, 3 DSP early, 4 DSP late |
| cfg_ratio | input | 2 | Bit periods per frame: 0=32, 1=48, 2=64 |
| cfg_width | input | 5 | Sample width W, 16 to 24 |
| cfg_lsb_first | input | 1 | 1 sends the LSB first |
| sclk_o | output | 1 | Serial bit clock |
| lrck_o | output | 1 | Word select / frame sync |
| sdata_o | output | 1 | Serial data |
| underrun_o | output | 1 | One-cycle pulse: frame started without a sample pair |

## Verification
Each of the five placements is driven with random sample words at several width and ratio pairs. Full-frame cases (16 at 32, 24 at 48) are the ones that expose the I2S and late-DSP spill into the next half-frame. Padded cases (for example 18 at 64) tell left, right and delayed alignment apart. Every case is also run LSB first, which separates the two bit orders. Configuration changes fall at random points inside frames, to show they wait for the frame edge. A stretch with no pairs offered shows the zero frames and the underrun pulse.

// File: rtl/sat_pkg.sv
package sat_pkg;

  localparam int unsigned SAT_MAX_W = 24;
  localparam int unsigned SAT_WF    = 5;
  localparam int unsigned SAT_SF    = 7;

  typedef enum logic [2:0] {
    FMT_LJ   = 3'd0,
    FMT_RJ   = 3'd1,
    FMT_I2S  = 3'd2,
    FMT_DSPA = 3'd3,
    FMT_DSPB = 3'd4
  } fmt_e;

  typedef struct packed {
    fmt_e              fmt;
    logic [1:0]        ratio;
    logic [SAT_WF-1:0] width;
    logic              lsb_first;
  } cfg_t;

  function automatic int frame_len(input logic [1:0] ratio);
    case (ratio)
      2'd0:    return 32;
      2'd1:    return 48;
      default: return 64;
    endcase
  endfunction

  // k counts transmitted bits from zero
  function automatic logic pick_bit(input logic [SAT_MAX_W-1:0] word,
                                    input logic [SAT_WF-1:0]    width,
                                    input int                   k,
                                    input logic                 lsb_first);
    int idx;
    idx = lsb_first ? k : (int'(width) - 1 - k);
    if (idx < 0 || idx >= int'(SAT_MAX_W) || k < 0 || k >= int'(width))
      return 1'b0;
    return word[idx];
  endfunction

  // the last bit of the frame falls past its end
  function automatic logic spills(input cfg_t c);
    int r;
    int w;
    r = frame_len(c.ratio);
    w = int'(c.width);
    return ((c.fmt == FMT_I2S) && (w == r / 2)) ||
           ((c.fmt == FMT_DSPB) && (2 * w == r));
  endfunction

endpackage

// File: rtl/sat_bclk_gen.sv
module sat_bclk_gen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic sclk
);
  localparam int unsigned PERIOD = 2 * HALF_DIV;
  localparam int unsigned CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] RISE = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;

  always_comb begin
    tick   = (cnt_q == LAST);
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
    sclk_d = sclk_q;
    if (tick)
      sclk_d = 1'b0;
    else if (cnt_q == RISE)
      sclk_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;

endmodule

// File: rtl/sat_frame_ctl.sv
module sat_frame_ctl
  import sat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  cfg_t                 cfg_in,
  input  logic                 in_valid,
  input  logic [SAT_MAX_W-1:0] in_left,
  input  logic [SAT_MAX_W-1:0] in_right,
  output logic                 in_ready,
  output cfg_t                 cfg_nx,
  output logic [SAT_MAX_W-1:0] left_nx,
  output logic [SAT_MAX_W-1:0] right_nx,
  output logic [SAT_SF-1:0]    slot_nx,
  output logic                 wrap_nx,
  output logic                 starve
);
  localparam cfg_t CFG_RST = '{fmt: FMT_LJ, ratio: 2'd0,
                               width: SAT_WF'(16), lsb_first: 1'b0};

  logic [SAT_SF-1:0]    slot_q, slot_d, last_slot;
  logic                 primed_q, primed_d;
  cfg_t                 cfg_q, cfg_d;
  logic [SAT_MAX_W-1:0] left_q, left_d, right_q, right_d;
  logic                 wrap_q, wrap_d;
  logic                 hold_full_q, hold_full_d;
  logic [SAT_MAX_W-1:0] hold_l_q, hold_l_d, hold_r_q, hold_r_d;
  logic                 bnd, accept;

  always_comb begin
    last_slot   = SAT_SF'(frame_len(cfg_q.ratio) - 1);
    bnd         = tick && (!primed_q || (slot_q == last_slot));
    accept      = in_valid && !hold_full_q;

    slot_d      = slot_q;
    primed_d    = primed_q;
    cfg_d       = cfg_q;
    left_d      = left_q;
    right_d     = right_q;
    wrap_d      = wrap_q;
    hold_l_d    = hold_l_q;
    hold_r_d    = hold_r_q;

    if (tick)
      slot_d = bnd ? '0 : slot_q + 1'b1;

    if (bnd) begin
      primed_d = 1'b1;
      cfg_d    = cfg_in;
      wrap_d   = (primed_q && spills(cfg_q)) ?
                 pick_bit(right_q, cfg_q.width, int'(cfg_q.width) - 1,
                          cfg_q.lsb_first) : 1'b0;
      left_d   = hold_full_q ? hold_l_q : '0;
      right_d  = hold_full_q ? hold_r_q : '0;
    end

    if (accept) begin
      hold_l_d = in_left;
      hold_r_d = in_right;
    end
    hold_full_d = accept ? 1'b1 : (bnd ? 1'b0 : hold_full_q);

    starve   = bnd && !hold_full_q;
    in_ready = !hold_full_q;
    cfg_nx   = cfg_d;
    left_nx  = left_d;
    right_nx = right_d;
    slot_nx  = slot_d;
    wrap_nx  = wrap_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q      <= '0;
      primed_q    <= 1'b0;
      cfg_q       <= CFG_RST;
      left_q      <= '0;
      right_q     <= '0;
      wrap_q      <= 1'b0;
      hold_full_q <= 1'b0;
      hold_l_q    <= '0;
      hold_r_q    <= '0;
    end else begin
      slot_q      <= slot_d;
      primed_q    <= primed_d;
      cfg_q       <= cfg_d;
      left_q      <= left_d;
      right_q     <= right_d;
      wrap_q      <= wrap_d;
      hold_full_q <= hold_full_d;
      hold_l_q    <= hold_l_d;
      hold_r_q    <= hold_r_d;
    end
  end

endmodule

// File: rtl/sat_slot_map.sv
module sat_slot_map
  import sat_pkg::*;
(
  input  logic [SAT_SF-1:0]    slot,
  input  cfg_t                 cfg,
  input  logic [SAT_MAX_W-1:0] left,
  input  logic [SAT_MAX_W-1:0] right,
  input  logic                 wrap,
  output logic                 bit_o,
  output logic                 lr_o
);
  int                   s, h, w, p, k;
  logic                 hi;
  logic [SAT_MAX_W-1:0] word;

  always_comb begin
    s     = int'(slot);
    h     = frame_len(cfg.ratio) / 2;
    w     = int'(cfg.width);
    hi    = (s >= h);
    p     = hi ? s - h : s;
    word  = hi ? right : left;
    k     = 0;
    bit_o = 1'b0;
    lr_o  = 1'b0;
    case (cfg.fmt)
      FMT_LJ: begin
        lr_o  = hi;
        bit_o = pick_bit(word, cfg.width, p, cfg.lsb_first);
      end
      FMT_RJ: begin
        lr_o  = hi;
        k     = p - (h - w);
        bit_o = pick_bit(word, cfg.width, k, cfg.lsb_first);
      end
      FMT_I2S: begin
        lr_o = hi;
        if (p == 0) begin
          if (!hi)
            bit_o = wrap;
          else if (w == h)
            bit_o = pick_bit(left, cfg.width, w - 1, cfg.lsb_first);
        end else begin
          bit_o = pick_bit(word, cfg.width, p - 1, cfg.lsb_first);
        end
      end
      FMT_DSPA: begin
        lr_o = (s == 0);
        if (s < w)
          bit_o = pick_bit(left, cfg.width, s, cfg.lsb_first);
        else
          bit_o = pick_bit(right, cfg.width, s - w, cfg.lsb_first);
      end
      FMT_DSPB: begin
        lr_o = (s == 0);
        if (s == 0) begin
          bit_o = wrap;
        end else begin
          k = s - 1;
          if (k < w)
            bit_o = pick_bit(left, cfg.width, k, cfg.lsb_first);
          else
            bit_o = pick_bit(right, cfg.width, k - w, cfg.lsb_first);
        end
      end
      default: begin
        bit_o = 1'b0;
        lr_o  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sat_tx.sv
module sat_tx
  import sat_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [SAT_MAX_W-1:0] in_left,
  input  logic [SAT_MAX_W-1:0] in_right,
  input  logic [2:0]           cfg_fmt,
  input  logic [1:0]           cfg_ratio,
  input  logic [SAT_WF-1:0]    cfg_width,
  input  logic                 cfg_lsb_first,
  output logic                 sclk_o,
  output logic                 lrck_o,
  output logic                 sdata_o,
  output logic                 underrun_o
);
  logic                 tick, starve, map_bit, map_lr, wrap_nx;
  cfg_t                 cfg_in, cfg_nx;
  logic [SAT_MAX_W-1:0] left_nx, right_nx;
  logic [SAT_SF-1:0]    slot_nx;
  logic                 sdata_q, sdata_d, lrck_q, lrck_d, ur_q, ur_d;

  assign cfg_in = '{fmt: fmt_e'(cfg_fmt), ratio: cfg_ratio,
                    width: cfg_width, lsb_first: cfg_lsb_first};

  sat_bclk_gen #(.HALF_DIV(HALF_DIV)) u_bclk (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .sclk (sclk_o)
  );

  sat_frame_ctl u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .cfg_in  (cfg_in),
    .in_valid(in_valid),
    .in_left (in_left),
    .in_right(in_right),
    .in_ready(in_ready),
    .cfg_nx  (cfg_nx),
    .left_nx (left_nx),
    .right_nx(right_nx),
    .slot_nx (slot_nx),
    .wrap_nx (wrap_nx),
    .starve  (starve)
  );

  sat_slot_map u_map (
    .slot (slot_nx),
    .cfg  (cfg_nx),
    .left (left_nx),
    .right(right_nx),
    .wrap (wrap_nx),
    .bit_o(map_bit),
    .lr_o (map_lr)
  );

  always_comb begin
    sdata_d = tick ? map_bit : sdata_q;
    lrck_d  = tick ? map_lr  : lrck_q;
    ur_d    = starve;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdata_q <= 1'b0;
      lrck_q  <= 1'b0;
      ur_q    <= 1'b0;
    end else begin
      sdata_q <= sdata_d;
      lrck_q  <= lrck_d;
      ur_q    <= ur_d;
    end
  end

  assign sdata_o    = sdata_q;
  assign lrck_o     = lrck_q;
  assign underrun_o = ur_q;

endmodule

// File: rtl/sat_tx_chk.sv
module sat_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic lrck,
  input logic sdata,
  input logic underrun,
  input logic in_valid,
  input logic in_ready
);
  // R8
  sdata_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sclk) |-> $stable(sdata));

  // R8
  lrck_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sclk) |-> $stable(lrck));

  // R9
  underrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  // R9
  underrun_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> $fell(sclk));

  // R11
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R11
  ready_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid));

endmodule

bind sat_tx sat_tx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sclk    (sclk_o),
  .lrck    (lrck_o),
  .sdata   (sdata_o),
  .underrun(underrun_o),
  .in_valid(in_valid),
  .in_ready(in_ready)
);

// File: tb/sim_sat_tx.sv
module sim_sat_tx;
  localparam int HALF = 2;

  logic        clk;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [23:0] in_left, in_right;
  logic [2:0]  cfg_fmt;
  logic [1:0]  cfg_ratio;
  logic [4:0]  cfg_width;
  logic        cfg_lsb_first;
  logic        sclk_o, lrck_o, sdata_o, underrun_o;

  int vec_cnt = 0;
  int err_cnt = 0;
  bit done = 0;
  bit feed_en = 0;
  bit hs_seen = 0;

  sat_tx #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .cfg_fmt(cfg_fmt),
    .cfg_ratio(cfg_ratio), .cfg_width(cfg_width),
    .cfg_lsb_first(cfg_lsb_first), .sclk_o(sclk_o), .lrck_o(lrck_o),
    .sdata_o(sdata_o), .underrun_o(underrun_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int len_of(input int ratio);
    return (ratio == 0) ? 32 : (ratio == 1) ? 48 : 64;
  endfunction

  // ---------------- reference model, sampled on falling clk edges ----------------
  logic [47:0] pairq[$];
  logic [47:0] pend;
  bit          pend_v;
  int          s_fmt, s_ratio, s_w, s_lsb;
  int          b_fmt, b_ratio, b_w, b_lsb, b_len, b_slot;
  bit          b_primed, carry, sclk_prev, seen_fall;
  logic [64:0] efr;
  logic [23:0] cur_l, cur_r;
  int          cyc;

  function automatic logic tx_bit(input logic [23:0] wd, input int k);
    return b_lsb ? wd[k] : wd[b_w - 1 - k];
  endfunction

  task automatic build_frame();
    int h;
    int pl;
    int pr;
    h   = b_len / 2;
    efr = '0;
    if (b_fmt == 2 || b_fmt == 4) efr[0] = carry;
    for (int k = 0; k < b_w; k++) begin
      case (b_fmt)
        0:       begin pl = k;             pr = h + k;             end
        1:       begin pl = h - b_w + k;   pr = b_len - b_w + k;   end
        2:       begin pl = 1 + k;         pr = h + 1 + k;         end
        3:       begin pl = k;             pr = b_w + k;           end
        default: begin pl = 1 + k;         pr = 1 + b_w + k;       end
      endcase
      efr[pl] = tx_bit(cur_l, k);
      efr[pr] = tx_bit(cur_r, k);
    end
    carry = efr[b_len];
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        pairq.delete();
        pend_v = 0; b_primed = 0; carry = 0; sclk_prev = 0;
        seen_fall = 0; cyc = 0; b_slot = 0; hs_seen = 0;
        b_fmt = 0; b_ratio = 0; b_w = 16; b_lsb = 0; b_len = 32;
      end else begin
        cyc++;
        if (sclk_prev && !sclk_o) begin
          string tag;
          bit exp_lr;
          bit mid;
          if (seen_fall) chk(cyc == 2 * HALF, "R8 bit period", cyc, 2 * HALF);
          seen_fall = 1;
          cyc = 0;
          if (!b_primed || b_slot == b_len - 1) begin
            bit empty;
            b_primed = 1;
            b_slot = 0;
            b_fmt = s_fmt; b_ratio = s_ratio; b_w = s_w; b_lsb = s_lsb;
            b_len = len_of(s_ratio);
            empty = (pairq.size() == 0);
            if (empty) begin cur_l = '0; cur_r = '0; end
            else begin {cur_l, cur_r} = pairq.pop_front(); end
            build_frame();
            chk(underrun_o == empty, "R9 underrun at frame start", underrun_o, empty);
          end else begin
            b_slot++;
            chk(underrun_o == 1'b0, "R9 underrun mid frame", underrun_o, 0);
          end
          case (b_fmt)
            0: tag = "R2 left-justified";
            1: tag = "R3 right-justified";
            2: tag = "R4 i2s";
            3: tag = "R5 dsp early";
            default: tag = "R6 dsp late";
          endcase
          if (b_lsb != 0) tag = {tag, " R7 lsb first"};
          mid = (s_fmt != b_fmt) || (s_ratio != b_ratio) || (s_w != b_w) || (s_lsb != b_lsb);
          if (mid) tag = {tag, " R10 held config"};
          chk(sdata_o == efr[b_slot], tag, sdata_o, efr[b_slot]);
          exp_lr = (b_fmt >= 3) ? (b_slot == 0) : (b_slot >= b_len / 2);
          chk(lrck_o == exp_lr, (b_fmt >= 3) ? "R5 sync pulse" : "R1 word select",
              lrck_o, exp_lr);
        end else if (underrun_o) begin
          chk(1'b0, "R9 underrun off edge", 1, 0);
        end
        if (pend_v) begin
          pairq.push_back(pend);
          chk(in_ready == 1'b0, "R11 ready low after transfer", in_ready, 0);
        end
        pend_v  = in_valid && in_ready;
        pend    = {in_left, in_right};
        hs_seen = pend_v;
        s_fmt = int'(cfg_fmt); s_ratio = int'(cfg_ratio);
        s_w = int'(cfg_width); s_lsb = int'(cfg_lsb_first);
      end
      sclk_prev = sclk_o;
    end
  end

  // ---------------- sample producer ----------------
  initial begin
    in_valid = 0; in_left = '0; in_right = '0;
    forever begin
      @(posedge clk);
      #1;
      if (!rst_n) begin
        in_valid = 0;
      end else if (hs_seen || !in_valid) begin
        if (feed_en) begin
          in_valid = 1;
          in_left  = 24'($urandom);
          in_right = 24'($urandom);
        end else begin
          in_valid = 0;
        end
      end
    end
  end

  task automatic run_cfg(input int fmt, input int ratio, input int w,
                         input int lsb, input int frames);
    @(posedge clk);
    #1;
    cfg_fmt = 3'(fmt); cfg_ratio = 2'(ratio);
    cfg_width = 5'(w); cfg_lsb_first = 1'(lsb);
    repeat (frames * len_of(ratio) * 2 * HALF + int'($urandom % 37)) @(posedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      err_cnt++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0;
    cfg_fmt = 3'd0; cfg_ratio = 2'd0; cfg_width = 5'd16; cfg_lsb_first = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R12 reset state
    chk(sclk_o == 0, "R12 sclk reset", sclk_o, 0);
    chk(lrck_o == 0, "R12 lrck reset", lrck_o, 0);
    chk(sdata_o == 0, "R12 sdata reset", sdata_o, 0);
    chk(underrun_o == 0, "R12 underrun reset", underrun_o, 0);
    chk(in_ready == 1, "R12 ready reset", in_ready, 1);
    @(posedge clk);
    #1;
    rst_n = 1;
    feed_en = 1;

    // directed corner cases
    run_cfg(0, 0, 16, 0, 4);   // R2 full half-frame
    run_cfg(1, 0, 16, 0, 4);   // R3 equals left-justified
    run_cfg(2, 0, 16, 0, 4);   // R4 spill into next half
    run_cfg(2, 1, 20, 1, 4);   // R4 padded, R7
    run_cfg(1, 2, 18, 0, 4);   // R3 leading pad
    run_cfg(0, 2, 24, 1, 4);   // R2 trailing pad, R7
    run_cfg(2, 1, 24, 0, 4);   // R4 spill at 48
    run_cfg(3, 0, 16, 0, 4);   // R5
    run_cfg(4, 1, 24, 1, 4);   // R6 spill into next frame
    run_cfg(4, 0, 16, 0, 4);   // R6
    run_cfg(3, 1, 24, 1, 3);   // R5 lsb first

    // R9 starvation
    feed_en = 0;
    run_cfg(0, 1, 20, 0, 4);
    feed_en = 1;
    run_cfg(2, 0, 16, 1, 3);

    // constrained random
    for (int n = 0; n < 24; n++) begin
      int f;
      int r;
      int w;
      f = int'($urandom % 5);
      if (f >= 3) begin
        if ($urandom % 2 == 0) begin r = 0; w = 16; end
        else begin r = 1; w = 24; end
      end else begin
        r = int'($urandom % 3);
        if (r == 0) w = 16;
        else if (r == 1) w = 16 + int'($urandom % 9);
        else w = 17 + int'($urandom % 8);
      end
      if (n == 10) feed_en = 0;
      if (n == 12) feed_en = 1;
      run_cfg(f, r, w, int'($urandom % 2), 3);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

endmodule